// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block arbitrates interrupt requests for a processor across a fixed set of priority levels. A few low-numbered levels are internal and carry a single request line each. Examples are a console request, power events and program requests. The remaining levels are external, and each of them is shared by a small group of source lines. Every source line has its own capture flip-flop. Software can arm, disarm, enable, disable or trigger each level through a single command port.

The controller keeps the level of the task that is currently running. A new interrupt is accepted only at an explicit test point, and only when interrupts are not masked. It must also beat the current level, where a lower level number means higher priority. When a request is accepted, the controller reports the level and the source index inside the group, clears that source's flip-flop, and takes the level as the current one. A deactivate strobe ends the current level and hands control to the best request still waiting. A source waiting at the same level is taken before any lower level. When nothing waits, the controller reports idle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every level is disarmed, disabled and has nothing pending. The outputs are `grant_o`=0, `lvl_o`=NUM_LVL (the idle code, 32 by default), `src_o`=0 and `idle_o`=1.
- R2: On an armed level, a source line sampled high sets that source's own pending flip-flop. The flip-flop stays set after the line drops, until that source is granted.
- R3: On a disarmed level, both source lines and software triggers are ignored. Arming the level later does not make it pending, and a test point grants nothing.
- R4: An armed but disabled level still captures requests and holds them pending, but is never granted. Once it is enabled, a test point grants the held request.
- R5: `cmd_op_i` encodes the commands as 0 arm, 1 disarm, 2 enable, 3 disable and 4 trigger, applied to level `cmd_lvl_i` when `cmd_valid_i` is 1. A trigger sets the pending flip-flop of source `cmd_src_i` exactly as a high source line would. Internal levels only have source 0.
- R6: A test strobe with `mask_i`=0 grants the best waiting request only if its level number is below `lvl_o`. In the next cycle `grant_o` pulses for one cycle, `lvl_o` and `src_o` show the accepted level and source, and that source's flip-flop is cleared. Otherwise the outputs hold.
- R7: While `mask_i`=1, a test strobe grants nothing.
- R8: Among enabled levels with something pending, the lowest level number wins, so level 0 has the highest priority.
- R9: Level l < NUM_INT is driven by `int_req_i[l]`. External level l ≥ NUM_INT with source s is driven by `ext_req_i[(l-NUM_INT)*SRC_PER+s]`. Within a level the lowest pending source index wins and is reported on `src_o`.
- R10: A deactivate strobe, regardless of mask and current level, grants the best waiting request (the same level's next source first, otherwise the next lower level). If nothing waits, it sets `lvl_o` to the idle code and `idle_o`=1 with no grant.
- R11: When test and deactivate are strobed in the same cycle, deactivate decides the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req_i | input | NUM_INT | Request lines of the internal levels |
| ext_req_i | input | (NUM_LVL-NUM_INT)*SRC_PER | Grouped request lines of the external levels |
| cmd_valid_i | input | 1 | Software command strobe |
| cmd_op_i | input | 3 | Command code (arm, disarm, enable, disable, trigger) |
| cmd_lvl_i | input | clog2(NUM_LVL) | Level addressed by the command |
| cmd_src_i | input | clog2(SRC_PER) | Source within the level, for trigger |
| mask_i | input | 1 | Global interrupt mask indicator |
| test_i | input | 1 | Interrupt test point strobe |
| deact_i | input | 1 | Deactivate current level strobe |
| grant_o | output | 1 | One-cycle pulse when a request is accepted |
| lvl_o | output | clog2(NUM_LVL)+1 | Current level, NUM_LVL when idle |
| src_o | output | clog2(SRC_PER) | Source index of the accepted request |
| idle_o | output | 1 | No level is active |

## Verification
The bench uses the default build: 32 levels, 4 of them internal, and groups of 4 sources. At this size every one of the 116 source lines can be walked individually through capture, grant and deactivate. Every one of the 496 ordered level pairs can also be checked for priority and hand-over order. Targeted sequences then cover the disarmed, disabled, masked and same-level tie cases. They also cover the case where a lower level does not preempt and the case where test and deactivate are strobed together.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    OP_ARM     = 3'd0,
    OP_DISARM  = 3'd1,
    OP_ENABLE  = 3'd2,
    OP_DISABLE = 3'd3,
    OP_TRIGGER = 3'd4
  } pic_op_e;
endpackage

// File: rtl/irq_level_bank.sv
module irq_level_bank
  import pic_pkg::*;
#(
  parameter int NUM_LVL = 32,
  parameter int NUM_INT = 4,
  parameter int SRC_PER = 4,
  localparam int LW = $clog2(NUM_LVL),
  localparam int SW = (SRC_PER > 1) ? $clog2(SRC_PER) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LVL*SRC_PER-1:0] raw_i,
  input  logic                       cmd_valid_i,
  input  logic [2:0]                 cmd_op_i,
  input  logic [LW-1:0]              cmd_lvl_i,
  input  logic [SW-1:0]              cmd_src_i,
  input  logic                       clr_i,
  input  logic [LW-1:0]              clr_lvl_i,
  input  logic [SW-1:0]              clr_src_i,
  output logic [NUM_LVL*SRC_PER-1:0] pend_o,
  output logic [NUM_LVL-1:0]         en_o
);

  pic_op_e op;
  assign op = pic_op_e'(cmd_op_i);

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic               arm_q;
    logic               en_q;
    logic               hit;
    logic [SRC_PER-1:0] pend_q;
    logic [SRC_PER-1:0] set_v;
    logic [SRC_PER-1:0] clr_v;

    assign hit = cmd_valid_i && (cmd_lvl_i == LW'(l));

    always_comb begin
      for (int s = 0; s < SRC_PER; s++) begin
        set_v[s] = arm_q && ((l >= NUM_INT) || (s == 0)) &&
                   (raw_i[l*SRC_PER+s] ||
                    (hit && op == OP_TRIGGER && cmd_src_i == SW'(s)));
        clr_v[s] = clr_i && (clr_lvl_i == LW'(l)) && (clr_src_i == SW'(s));
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        arm_q  <= 1'b0;
        en_q   <= 1'b0;
        pend_q <= '0;
      end else begin
        if (hit) begin
          case (op)
            OP_ARM:     arm_q <= 1'b1;
            OP_DISARM:  arm_q <= 1'b0;
            OP_ENABLE:  en_q  <= 1'b1;
            OP_DISABLE: en_q  <= 1'b0;
            default:    ;
          endcase
        end
        pend_q <= (pend_q & ~clr_v) | set_v;
      end
    end

    assign pend_o[l*SRC_PER +: SRC_PER] = pend_q;
    assign en_o[l] = en_q;

    AST_DISARM_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      !$past(arm_q) |-> ((pend_q & ~$past(pend_q)) == '0)); // R3
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_LVL = 32,
  parameter int SRC_PER = 4,
  localparam int LW = $clog2(NUM_LVL),
  localparam int SW = (SRC_PER > 1) ? $clog2(SRC_PER) : 1
) (
  input  logic [NUM_LVL*SRC_PER-1:0] pend_i,
  input  logic [NUM_LVL-1:0]         en_i,
  output logic                       any_o,
  output logic [LW-1:0]              lvl_o,
  output logic [SW-1:0]              src_o
);

  always_comb begin
    any_o = 1'b0;
    lvl_o = '0;
    src_o = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (en_i[l] && (|pend_i[l*SRC_PER +: SRC_PER])) begin
        any_o = 1'b1;
        lvl_o = LW'(l);
        for (int s = SRC_PER - 1; s >= 0; s--) begin
          if (pend_i[l*SRC_PER+s]) src_o = SW'(s);
        end
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_LVL = 32,
  parameter int NUM_INT = 4,
  parameter int SRC_PER = 4,
  localparam int NUM_EXT = (NUM_LVL - NUM_INT) * SRC_PER,
  localparam int LW = $clog2(NUM_LVL),
  localparam int CW = LW + 1,
  localparam int SW = (SRC_PER > 1) ? $clog2(SRC_PER) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_INT-1:0] int_req_i,
  input  logic [NUM_EXT-1:0] ext_req_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_op_i,
  input  logic [LW-1:0]      cmd_lvl_i,
  input  logic [SW-1:0]      cmd_src_i,
  input  logic               mask_i,
  input  logic               test_i,
  input  logic               deact_i,
  output logic               grant_o,
  output logic [CW-1:0]      lvl_o,
  output logic [SW-1:0]      src_o,
  output logic               idle_o
);

  localparam logic [CW-1:0] IDLE = CW'(NUM_LVL);

  logic [NUM_LVL*SRC_PER-1:0] raw;
  logic [NUM_LVL*SRC_PER-1:0] pend;
  logic [NUM_LVL-1:0]         en;
  logic                       pk_any;
  logic [LW-1:0]              pk_lvl;
  logic [SW-1:0]              pk_src;
  logic                       take_test;
  logic                       clr;
  logic [CW-1:0]              cur_q;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_map
    for (genvar s = 0; s < SRC_PER; s++) begin : g_src
      if (l < NUM_INT) begin : g_int
        if (s == 0) begin : g_first
          assign raw[l*SRC_PER+s] = int_req_i[l];
        end else begin : g_none
          assign raw[l*SRC_PER+s] = 1'b0;
        end
      end else begin : g_ext
        assign raw[l*SRC_PER+s] = ext_req_i[(l-NUM_INT)*SRC_PER+s];
      end
    end
  end

  irq_level_bank #(
    .NUM_LVL(NUM_LVL), .NUM_INT(NUM_INT), .SRC_PER(SRC_PER)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .raw_i      (raw),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_op_i),
    .cmd_lvl_i  (cmd_lvl_i),
    .cmd_src_i  (cmd_src_i),
    .clr_i      (clr),
    .clr_lvl_i  (pk_lvl),
    .clr_src_i  (pk_src),
    .pend_o     (pend),
    .en_o       (en)
  );

  irq_pick #(.NUM_LVL(NUM_LVL), .SRC_PER(SRC_PER)) u_pick (
    .pend_i(pend),
    .en_i  (en),
    .any_o (pk_any),
    .lvl_o (pk_lvl),
    .src_o (pk_src)
  );

  assign take_test = test_i && !deact_i && !mask_i && pk_any &&
                     ({1'b0, pk_lvl} < cur_q);
  assign clr = take_test || (deact_i && pk_any);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= IDLE;
      grant_o <= 1'b0;
      src_o   <= '0;
      idle_o  <= 1'b1;
    end else begin
      grant_o <= 1'b0;
      if (clr) begin
        cur_q   <= {1'b0, pk_lvl};
        src_o   <= pk_src;
        grant_o <= 1'b1;
        idle_o  <= 1'b0;
      end else if (deact_i) begin
        cur_q  <= IDLE;
        src_o  <= '0;
        idle_o <= 1'b1;
      end
    end
  end

  assign lvl_o = cur_q;

  AST_GRANT_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> $past(test_i || deact_i)); // R6
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (grant_o && !$past(deact_i)) |-> !$past(mask_i)); // R7
  AST_PREEMPT_HIGHER: assert property (@(posedge clk) disable iff (rst)
    (grant_o && !$past(deact_i)) |-> (lvl_o < $past(lvl_o))); // R6
  AST_DEACT_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(deact_i) && !grant_o) |-> (idle_o && lvl_o == IDLE)); // R10
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$past(test_i || deact_i) |-> $stable(lvl_o)); // R6

endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int NL = 32, NI = 4, SP = 4, NE = (NL - NI) * SP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0] int_req = '0;
  logic [NE-1:0] ext_req = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [4:0] cmd_lvl = '0;
  logic [1:0] cmd_src = '0;
  logic mask = 1'b0, test = 1'b0, deact = 1'b0;
  logic grant, idle;
  logic [5:0] lvl;
  logic [1:0] src;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_LVL(NL), .NUM_INT(NI), .SRC_PER(SP)) u0 (
    .clk(clk), .rst(rst), .int_req_i(int_req), .ext_req_i(ext_req),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_lvl_i(cmd_lvl),
    .cmd_src_i(cmd_src), .mask_i(mask), .test_i(test), .deact_i(deact),
    .grant_o(grant), .lvl_o(lvl), .src_o(src), .idle_o(idle)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic see(input string tag, input int g, input int l, input int s, input int i);
    chk({tag, " grant"}, int'(grant), g);
    chk({tag, " lvl"}, int'(lvl), l);
    chk({tag, " src"}, int'(src), s);
    chk({tag, " idle"}, int'(idle), i);
  endtask

  task automatic cmd(input int op, input int l, input int s);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_lvl = 5'(l); cmd_src = 2'(s);
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic raise(input int l, input int s);
    if (l < NI) int_req[l] = 1'b1;
    else ext_req[(l-NI)*SP+s] = 1'b1;
    tick();
    int_req = '0; ext_req = '0;
  endtask

  task automatic strobe(input bit t, input bit d);
    test = t; deact = d;
    tick();
    test = 1'b0; deact = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    see("R1 reset", 0, NL, 0, 1);

    // R3: disarmed level ignores lines and triggers
    raise(10, 0);
    cmd(0, 10, 0); cmd(2, 10, 0);
    strobe(1, 0);
    see("R3 line disarmed", 0, NL, 0, 1);
    cmd(4, 11, 0);
    cmd(0, 11, 0); cmd(2, 11, 0);
    strobe(1, 0);
    see("R3 trigger disarmed", 0, NL, 0, 1);

    for (int l = 0; l < NL; l++) begin
      cmd(0, l, 0); cmd(2, l, 0);
    end

    // R2 / R9: every source line individually
    for (int l = 0; l < NL; l++) begin
      for (int s = 0; s < ((l < NI) ? 1 : SP); s++) begin
        raise(l, s);
        tick();
        strobe(1, 0);
        see("R2 R9 capture", 1, l, s, 0);
        strobe(0, 1);
        see("R10 empty deact", 0, NL, 0, 1);
      end
    end

    // R4: disabled level holds
    cmd(3, 7, 0);
    raise(7, 2);
    strobe(1, 0);
    see("R4 disabled", 0, NL, 0, 1);
    cmd(2, 7, 0);
    strobe(1, 0);
    see("R4 enabled", 1, 7, 2, 0);
    strobe(0, 1);

    // R7: mask
    mask = 1'b1;
    raise(12, 0);
    strobe(1, 0);
    see("R7 masked", 0, NL, 0, 1);
    mask = 1'b0;
    strobe(1, 0);
    see("R7 unmasked", 1, 12, 0, 0);
    strobe(0, 1);

    // R5: triggers
    cmd(4, 2, 0);
    strobe(1, 0);
    see("R5 trig internal", 1, 2, 0, 0);
    strobe(0, 1);
    cmd(4, 20, 3);
    strobe(1, 0);
    see("R5 trig external", 1, 20, 3, 0);
    strobe(0, 1);

    // R8 / R10: all level pairs
    for (int a = 0; a < NL - 1; a++) begin
      for (int b = a + 1; b < NL; b++) begin
        cmd(4, b, 0); cmd(4, a, 0);
        strobe(1, 0);
        see("R8 pair", 1, a, 0, 0);
        strobe(0, 1);
        see("R10 next lower", 1, b, 0, 0);
        strobe(0, 1);
        see("R10 drain", 0, NL, 0, 1);
      end
    end

    // R6: lower level does not preempt, higher does
    cmd(4, 6, 0);
    strobe(1, 0);
    see("R6 first", 1, 6, 0, 0);
    cmd(4, 15, 0);
    strobe(1, 0);
    see("R6 lower holds", 0, 6, 0, 0);
    cmd(4, 1, 0);
    strobe(1, 0);
    see("R6 preempt", 1, 1, 0, 0);
    strobe(0, 1);
    see("R6 R10 hand-over", 1, 15, 0, 0);
    strobe(0, 1);

    // R9 / R10: same-level tie and same-level next
    ext_req[(5-NI)*SP+3] = 1'b1;
    ext_req[(5-NI)*SP+1] = 1'b1;
    tick();
    ext_req = '0;
    strobe(1, 0);
    see("R9 tie", 1, 5, 1, 0);
    strobe(0, 1);
    see("R10 same level", 1, 5, 3, 0);
    strobe(0, 1);
    see("R10 idle", 0, NL, 0, 1);

    // R11: deactivate wins over test
    cmd(4, 3, 0);
    strobe(1, 0);
    cmd(4, 9, 0);
    strobe(1, 1);
    see("R11 both", 1, 9, 0, 0);
    strobe(0, 1);

    // R10: deactivate ignores mask
    mask = 1'b1;
    cmd(4, 8, 0);
    strobe(0, 1);
    see("R10 masked deact", 1, 8, 0, 0);
    mask = 1'b0;
    strobe(0, 1);
    see("R10 end", 0, NL, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule